// File: doc/BRIEF.md
# Multi-Slot SD Host Global Register Block

This block is the shared register front end placed ahead of one or two SD host slot controllers. A simple 32-bit register bus (valid, write flag, 12-bit byte address, write data) reaches a 4 KiB window. The first 256 bytes are the block's own registers:
- a slot-info register with slot-presence bits and a self-clearing controller reset request;
- plain configuration words;
- a per-slot shadow of the 64-bit capability word and of the maximum-current word, each visible as 32-bit halves;
- a read-only interrupt status register.

Each configured slot n owns the 256-byte page starting at (n+1)*0x100. An access there is passed straight to that slot's port.

Read data comes back one cycle after the request with a valid strobe. Writes take effect at the clock edge that accepts them and return no response. The level interrupt inputs of the slots are sampled into the status register, and a single combined interrupt line is derived from it.

Two small state machines carry the timing:
- **Response machine.** It has the states RSP_IDLE and RSP_DATA. A read request moves it to RSP_DATA, and it stays there while reads keep arriving back to back. Any cycle without a read returns it to RSP_IDLE.
- **Reset-request machine.** It has the states RS_IDLE and RS_PULSE. A write to the info register with bit 0 set moves it to RS_PULSE. It leaves RS_PULSE after one cycle unless the same write repeats.

Top module: `sdw_wrap_regs`

## Requirements
- R1: After reset, the block reads as follows:
  - info (0x00) is 0x00010000 with one slot and 0x00030000 with two slots; bit 16+n flags slot n present.
  - debounce (0x04) is 0x00000005.
  - 0x08, 0xEC, 0xF0 and the status register 0xFC read zero.
  - every capability shadow equals the CAP_INIT parameter, and every maximum-current shadow is zero.
  - irq_out, ctl_rst_req and slot_sel are low.
- R2: A write to info stores the value with bit 0 forced to zero, so bit 0 always reads as zero.
- R3: A write to info with bit 0 set raises ctl_rst_req for exactly the one cycle after the write edge. A write with bit 0 clear does not raise it.
- R4: Slot n's capability word is written and read as a low half at 0x10*(n+1) and a high half at 0x10*(n+1)+4. A write to one half keeps the other half.
- R5: Slot n's maximum-current word sits at 0x10*(n+1)+8. A write there changes only that slot's word.
- R6: Status bit n (0xFC) takes the level of slot_irq[n] at each clock edge. Bus writes to 0xFC are ignored.
- R7: irq_out is high exactly when at least one status bit is set. It stays high while any slot still asserts its interrupt.
- R8: An access at (n+1)*0x100 + off, for a configured slot n, routes to that slot:
  - slot_sel[n] alone is raised;
  - slot_addr carries off, and slot_write and slot_wdata follow the request;
  - a read returns slot n's slot_rdata word (bits 32n+31..32n).
- R9: The following read as zero, and writes to them change nothing and raise no slot_sel:
  - pages at or above (NUM_SLOTS+1)*0x100;
  - unmapped offsets in the first page, for example 0x0C and 0x30.
- R10: A read gives rsp_valid with its data in the following cycle. A write never gives rsp_valid.
- R11: Debounce (0x04), bus configuration (0x08), write-protect polarity (0xEC) and card-detect (0xF0) store and return all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the 4 KiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| slot_sel | output | NUM_SLOTS | Per-slot access strobe |
| slot_write | output | 1 | Write flag towards the slots |
| slot_addr | output | 8 | Offset inside the slot page |
| slot_wdata | output | 32 | Write data towards the slots |
| slot_rdata | input | 32*NUM_SLOTS | Combinational read data from the slots |
| slot_irq | input | NUM_SLOTS | Level interrupt from each slot |
| irq_out | output | 1 | Combined interrupt |
| ctl_rst_req | output | 1 | One-cycle controller reset request |

## Verification
Most state in this block surfaces only through reads, so a corrupted shadow half or configuration word shows up on the first read of that offset. That read returns in the very next cycle. A wrong status register or reset-request state shows up at irq_out or ctl_rst_req one cycle after the stimulus edge. Slot isolation is probed by writing one slot's shadow and reading the other slot's shadow back. Writes to ignored offsets are followed by reads of the same offset, and by watching slot_sel during the write.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int OFF_W     = 8;
    localparam int PAGE_W    = ADDR_W - OFF_W;

    localparam logic [OFF_W-1:0] OFF_INFO     = 8'h00;
    localparam logic [OFF_W-1:0] OFF_DEBOUNCE = 8'h04;
    localparam logic [OFF_W-1:0] OFF_BUSCFG   = 8'h08;
    localparam logic [OFF_W-1:0] OFF_WPPOL    = 8'hEC;
    localparam logic [OFF_W-1:0] OFF_CDET     = 8'hF0;
    localparam logic [OFF_W-1:0] OFF_ISTAT    = 8'hFC;

    localparam int          INFO_PRESENT_LSB = 16;
    localparam int          INFO_RST_BIT     = 0;
    localparam logic [31:0] DEBOUNCE_INIT    = 32'h0000_0005;

    typedef enum logic [1:0] {RGN_GLOBAL, RGN_SLOT, RGN_NONE} region_e;

    typedef enum logic [3:0] {
        FLD_INFO, FLD_DEBOUNCE, FLD_BUSCFG, FLD_WPPOL, FLD_CDET,
        FLD_ISTAT, FLD_CAP_LO, FLD_CAP_HI, FLD_MAXCUR, FLD_NONE
    } field_e;

    typedef enum logic {RSP_IDLE, RSP_DATA} rsp_state_e;
    typedef enum logic {RS_IDLE, RS_PULSE}  rst_state_e;

    function automatic logic [31:0] info_init(input int slots);
        logic [31:0] v;
        v = '0;
        for (int n = 0; n < slots; n++) v[INFO_PRESENT_LSB + n] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/sdw_decode.sv
module sdw_decode
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int SLOT_IW   = 1
) (
    input  logic [ADDR_W-1:0]  addr,
    output region_e            region,
    output field_e             field,
    output logic [SLOT_IW-1:0] slot_idx,
    output logic [OFF_W-1:0]   win_off
);
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  off;

    assign page    = addr[ADDR_W-1:OFF_W];
    assign off     = addr[OFF_W-1:0];
    assign win_off = off;

    always_comb begin
        region   = RGN_NONE;
        field    = FLD_NONE;
        slot_idx = '0;
        if (page == '0) begin
            region = RGN_GLOBAL;
            case (off)
                OFF_INFO:     field = FLD_INFO;
                OFF_DEBOUNCE: field = FLD_DEBOUNCE;
                OFF_BUSCFG:   field = FLD_BUSCFG;
                OFF_WPPOL:    field = FLD_WPPOL;
                OFF_CDET:     field = FLD_CDET;
                OFF_ISTAT:    field = FLD_ISTAT;
                default:      field = FLD_NONE;
            endcase
            // per-slot shadow rows live at 0x10*(n+1)
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (off[7:4] == 4'(n + 1)) begin
                    slot_idx = SLOT_IW'(n);
                    case (off[3:0])
                        4'h0:    field = FLD_CAP_LO;
                        4'h4:    field = FLD_CAP_HI;
                        4'h8:    field = FLD_MAXCUR;
                        default: field = FLD_NONE;
                    endcase
                end
            end
        end else begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (page == PAGE_W'(n + 1)) begin
                    region   = RGN_SLOT;
                    slot_idx = SLOT_IW'(n);
                end
            end
        end
    end
endmodule

// File: rtl/sdw_shadow.sv
module sdw_shadow
    import sdw_pkg::*;
#(
    parameter logic [63:0] CAP_INIT = 64'h0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  field_e            fld,
    input  logic [DATA_W-1:0] wdata,
    output logic [63:0]       cap_q,
    output logic [DATA_W-1:0] maxcur_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q    <= CAP_INIT;
            maxcur_q <= '0;
        end else if (wr_en) begin
            case (fld)
                FLD_CAP_LO: cap_q[31:0]  <= wdata;
                FLD_CAP_HI: cap_q[63:32] <= wdata;
                FLD_MAXCUR: maxcur_q     <= wdata;
                default:    ;
            endcase
        end
    end

    // R4: a low-half write leaves the high half untouched, and the reverse
    assert_cap_hi_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_CAP_LO) |=> $stable(cap_q[63:32]));
    assert_cap_lo_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_CAP_HI) |=> $stable(cap_q[31:0]));
    // R5: maximum-current word only changes on its own slot's write
    assert_maxcur_own_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && fld == FLD_MAXCUR) |=> $stable(maxcur_q));
endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
#(
    parameter int NUM_SLOTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  field_e               fld,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_SLOTS-1:0] slot_irq,
    output logic [DATA_W-1:0]    info_q,
    output logic [DATA_W-1:0]    debounce_q,
    output logic [DATA_W-1:0]    buscfg_q,
    output logic [DATA_W-1:0]    wppol_q,
    output logic [DATA_W-1:0]    cdet_q,
    output logic [DATA_W-1:0]    istat_q,
    output logic                 irq_out,
    output logic                 ctl_rst_req
);
    localparam logic [DATA_W-1:0] INFO_INIT = info_init(NUM_SLOTS);

    rst_state_e rs_state, rs_next;
    logic       rst_hit;

    assign rst_hit = wr_en && (fld == FLD_INFO) && wdata[INFO_RST_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_state <= RS_IDLE;
        else        rs_state <= rs_next;
    end

    always_comb begin
        rs_next = rs_state;
        unique case (rs_state)
            RS_IDLE:  if (rst_hit) rs_next = RS_PULSE;
            RS_PULSE: rs_next = rst_hit ? RS_PULSE : RS_IDLE;
        endcase
    end

    always_comb begin
        ctl_rst_req = (rs_state == RS_PULSE);
        irq_out     = |istat_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            info_q     <= INFO_INIT;
            debounce_q <= DEBOUNCE_INIT;
            buscfg_q   <= '0;
            wppol_q    <= '0;
            cdet_q     <= '0;
        end else if (wr_en) begin
            case (fld)
                FLD_INFO: begin
                    info_q               <= wdata;
                    info_q[INFO_RST_BIT] <= 1'b0;
                end
                FLD_DEBOUNCE: debounce_q <= wdata;
                FLD_BUSCFG:   buscfg_q   <= wdata;
                FLD_WPPOL:    wppol_q    <= wdata;
                FLD_CDET:     cdet_q     <= wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) istat_q <= '0;
        else        istat_q <= DATA_W'(slot_irq);
    end

    // R3: a reset-request write yields the pulse in the next cycle
    assert_rst_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit |=> ctl_rst_req);
    assert_rst_only_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_req |-> $past(rst_hit));
    // R6: status follows the slot interrupt levels, whatever the bus writes
    assert_istat_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (istat_q == DATA_W'($past(slot_irq))));
    // R2: the reset-request bit never reads back as one
    assert_info_bit0_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fld == FLD_INFO) |=> !info_q[INFO_RST_BIT]);
endmodule

// File: rtl/sdw_wrap_regs.sv
module sdw_wrap_regs
    import sdw_pkg::*;
#(
    parameter int          NUM_SLOTS = 2,
    parameter logic [63:0] CAP_INIT  = 64'h0000_0000_0000_0000
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [11:0]                 req_addr,
    input  logic [31:0]                 req_wdata,
    output logic                        rsp_valid,
    output logic [31:0]                 rsp_rdata,
    output logic [NUM_SLOTS-1:0]        slot_sel,
    output logic                        slot_write,
    output logic [7:0]                  slot_addr,
    output logic [31:0]                 slot_wdata,
    input  logic [32*NUM_SLOTS-1:0]     slot_rdata,
    input  logic [NUM_SLOTS-1:0]        slot_irq,
    output logic                        irq_out,
    output logic                        ctl_rst_req
);
    localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    region_e            region;
    field_e             field;
    logic [SLOT_IW-1:0] slot_idx;
    logic [OFF_W-1:0]   win_off;

    sdw_decode #(.NUM_SLOTS(NUM_SLOTS), .SLOT_IW(SLOT_IW)) u_dec (
        .addr(req_addr), .region(region), .field(field),
        .slot_idx(slot_idx), .win_off(win_off)
    );

    logic gen_wr;
    assign gen_wr = req_valid && req_write && (region == RGN_GLOBAL);

    logic [DATA_W-1:0] info_q, debounce_q, buscfg_q, wppol_q, cdet_q, istat_q;

    sdw_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(gen_wr), .fld(field),
        .wdata(req_wdata), .slot_irq(slot_irq),
        .info_q(info_q), .debounce_q(debounce_q), .buscfg_q(buscfg_q),
        .wppol_q(wppol_q), .cdet_q(cdet_q), .istat_q(istat_q),
        .irq_out(irq_out), .ctl_rst_req(ctl_rst_req)
    );

    logic [63:0]       cap_arr    [NUM_SLOTS];
    logic [DATA_W-1:0] maxcur_arr [NUM_SLOTS];
    logic [DATA_W-1:0] srd_arr    [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sh_wr;
        assign sh_wr = gen_wr && (slot_idx == SLOT_IW'(g)) &&
                       (field == FLD_CAP_LO || field == FLD_CAP_HI || field == FLD_MAXCUR);
        sdw_shadow #(.CAP_INIT(CAP_INIT)) u_sh (
            .clk(clk), .rst_n(rst_n), .wr_en(sh_wr), .fld(field),
            .wdata(req_wdata), .cap_q(cap_arr[g]), .maxcur_q(maxcur_arr[g])
        );
        assign srd_arr[g]  = slot_rdata[32*g +: 32];
        assign slot_sel[g] = req_valid && (region == RGN_SLOT) && (slot_idx == SLOT_IW'(g));
    end

    assign slot_write = req_valid && req_write && (region == RGN_SLOT);
    assign slot_addr  = win_off;
    assign slot_wdata = req_wdata;

    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        if (region == RGN_SLOT) begin
            for (int n = 0; n < NUM_SLOTS; n++)
                if (slot_idx == SLOT_IW'(n)) rd_mux = srd_arr[n];
        end else if (region == RGN_GLOBAL) begin
            for (int n = 0; n < NUM_SLOTS; n++) begin
                if (slot_idx == SLOT_IW'(n)) begin
                    if (field == FLD_CAP_LO) rd_mux = cap_arr[n][31:0];
                    if (field == FLD_CAP_HI) rd_mux = cap_arr[n][63:32];
                    if (field == FLD_MAXCUR) rd_mux = maxcur_arr[n];
                end
            end
            case (field)
                FLD_INFO:     rd_mux = info_q;
                FLD_DEBOUNCE: rd_mux = debounce_q;
                FLD_BUSCFG:   rd_mux = buscfg_q;
                FLD_WPPOL:    rd_mux = wppol_q;
                FLD_CDET:     rd_mux = cdet_q;
                FLD_ISTAT:    rd_mux = istat_q;
                default:      ;
            endcase
        end
    end

    // response machine
    rsp_state_e        rsp_state, rsp_next;
    logic              rd_req;
    logic [DATA_W-1:0] rdata_q;

    assign rd_req = req_valid && !req_write;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_state <= RSP_IDLE;
        else        rsp_state <= rsp_next;
    end

    always_comb begin
        rsp_next = rsp_state;
        unique case (rsp_state)
            RSP_IDLE: if (rd_req) rsp_next = RSP_DATA;
            RSP_DATA: rsp_next = rd_req ? RSP_DATA : RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_mux;
    end

    always_comb begin
        rsp_valid = (rsp_state == RSP_DATA);
        rsp_rdata = rsp_valid ? rdata_q : '0;
    end

    // R8: at most one slot strobe
    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_sel));
    // R9: pages beyond the configured slots never strobe a slot
    assert_no_sel_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_addr[11:8] > 4'(NUM_SLOTS)) |-> (slot_sel == '0));
    // R10: read response timing, and no response for writes
    assert_rsp_follows_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid);
    assert_rsp_only_after_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(rd_req));
    // R7: the combined line only rises after a slot raised its interrupt
    assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|slot_irq));
    // R1: parameter range
    initial assert_slots_range_R1: assert (NUM_SLOTS >= 1 && NUM_SLOTS <= 2);
endmodule

// File: tb/sim_sdw_wrap_regs.sv
module sim_sdw_wrap_regs;
    localparam int          CLK_PERIOD = 10;
    localparam int          NS         = 2;
    localparam logic [63:0] CAP_INIT   = 64'h1E6B_00C8_3276_32B2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic [11:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NS-1:0]     slot_sel;
    logic              slot_write;
    logic [7:0]        slot_addr;
    logic [31:0]       slot_wdata;
    logic [32*NS-1:0]  slot_rdata;
    logic [NS-1:0]     slot_irq = '0;
    logic              irq_out, ctl_rst_req;

    int total = 0;
    int bad   = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    // slot model: slot n answers 0x5A00_0000 | n<<20 | offset
    assign slot_rdata = {32'h5A10_0000 | 32'(slot_addr), 32'h5A00_0000 | 32'(slot_addr)};

    sdw_wrap_regs #(.NUM_SLOTS(NS), .CAP_INIT(CAP_INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .slot_sel(slot_sel), .slot_write(slot_write),
        .slot_addr(slot_addr), .slot_wdata(slot_wdata), .slot_rdata(slot_rdata),
        .slot_irq(slot_irq), .irq_out(irq_out), .ctl_rst_req(ctl_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // monitor: compare every response against the scoreboard queue (R10)
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R10 unexpected response actual=0x%08h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_out", 32'(irq_out), 0);
        check("R1 ctl_rst_req", 32'(ctl_rst_req), 0);
        check("R1 slot_sel", 32'(slot_sel), 0);
        bus_rd(12'h000, 32'h0003_0000, "R1 info");
        bus_rd(12'h004, 32'h0000_0005, "R1 debounce");
        bus_rd(12'h008, 0, "R1 buscfg");
        bus_rd(12'h0EC, 0, "R1 wppol");
        bus_rd(12'h0F0, 0, "R1 cdet");
        bus_rd(12'h0FC, 0, "R1 istat");
        bus_rd(12'h010, CAP_INIT[31:0],  "R1 cap0 lo");
        bus_rd(12'h014, CAP_INIT[63:32], "R1 cap0 hi");
        bus_rd(12'h020, CAP_INIT[31:0],  "R1 cap1 lo");
        bus_rd(12'h024, CAP_INIT[63:32], "R1 cap1 hi");
        bus_rd(12'h018, 0, "R1 maxcur0");
        bus_rd(12'h028, 0, "R1 maxcur1");

        // R11 full-width general registers
        bus_wr(12'h008, 32'hDEAD_BEEF);
        bus_wr(12'h0EC, 32'h8000_0001);
        bus_wr(12'h0F0, 32'h0F0F_A5A5);
        bus_wr(12'h004, 32'hFFFF_0000);
        bus_rd(12'h008, 32'hDEAD_BEEF, "R11 buscfg");
        bus_rd(12'h0EC, 32'h8000_0001, "R11 wppol");
        bus_rd(12'h0F0, 32'h0F0F_A5A5, "R11 cdet");
        bus_rd(12'h004, 32'hFFFF_0000, "R11 debounce");

        // R2 / R3 reset request
        bus_wr(12'h000, 32'hFFFF_FFFF);
        check("R3 pulse high", 32'(ctl_rst_req), 1);
        @(posedge clk); #1;
        check("R3 pulse one cycle", 32'(ctl_rst_req), 0);
        bus_rd(12'h000, 32'hFFFF_FFFE, "R2 info bit0 clear");
        bus_wr(12'h000, 32'h0003_0000);
        check("R3 no pulse bit0 clear", 32'(ctl_rst_req), 0);
        bus_rd(12'h000, 32'h0003_0000, "R2 info rewrite");

        // R4 capability halves
        bus_wr(12'h010, 32'h1111_2222);
        bus_rd(12'h010, 32'h1111_2222, "R4 cap0 lo written");
        bus_rd(12'h014, CAP_INIT[63:32], "R4 cap0 hi kept");
        bus_wr(12'h014, 32'h3333_4444);
        bus_rd(12'h010, 32'h1111_2222, "R4 cap0 lo kept");
        bus_rd(12'h014, 32'h3333_4444, "R4 cap0 hi written");
        bus_rd(12'h020, CAP_INIT[31:0], "R4 cap1 lo untouched");
        bus_wr(12'h024, 32'h7777_8888);
        bus_rd(12'h024, 32'h7777_8888, "R4 cap1 hi written");
        bus_rd(12'h014, 32'h3333_4444, "R4 cap0 hi isolated");

        // R5 maximum-current isolation
        bus_wr(12'h018, 32'hAAAA_5555);
        bus_wr(12'h028, 32'h0000_0F0F);
        bus_rd(12'h018, 32'hAAAA_5555, "R5 maxcur0 kept");
        bus_rd(12'h028, 32'h0000_0F0F, "R5 maxcur1");

        // R6 / R7 interrupts
        @(negedge clk); slot_irq = 2'b10;
        @(negedge clk);
        check("R7 irq_out on", 32'(irq_out), 1);
        bus_rd(12'h0FC, 32'h2, "R6 istat slot1");
        bus_wr(12'h0FC, 32'h0);
        bus_rd(12'h0FC, 32'h2, "R6 istat read-only");
        @(negedge clk); slot_irq = 2'b11;
        @(negedge clk); slot_irq = 2'b01;
        @(negedge clk);
        check("R7 irq_out held", 32'(irq_out), 1);
        bus_rd(12'h0FC, 32'h1, "R6 istat slot0 only");
        @(negedge clk); slot_irq = 2'b00;
        @(negedge clk);
        check("R7 irq_out off", 32'(irq_out), 0);
        bus_rd(12'h0FC, 32'h0, "R6 istat cleared");

        // R8 slot routing
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h240; req_wdata = 32'h1234_5678;
        #1;
        check("R8 sel slot1", 32'(slot_sel), 32'h2);
        check("R8 slot_addr", 32'(slot_addr), 32'h40);
        check("R8 slot_write", 32'(slot_write), 1);
        check("R8 slot_wdata", slot_wdata, 32'h1234_5678);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        bus_rd(12'h124, 32'h5A00_0024, "R8 slot0 read");
        bus_rd(12'h204, 32'h5A10_0004, "R8 slot1 read");

        // R9 unmapped and unconfigured
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 12'h340; req_wdata = 32'hFFFF_FFFF;
        #1;
        check("R9 no sel beyond slots", 32'(slot_sel), 0);
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        bus_rd(12'h300, 32'h0, "R9 page3 reads zero");
        bus_rd(12'hFFC, 32'h0, "R9 top reads zero");
        bus_wr(12'h00C, 32'hCAFE_F00D);
        bus_rd(12'h00C, 32'h0, "R9 0x0C reads zero");
        bus_wr(12'h030, 32'hCAFE_F00D);
        bus_rd(12'h030, 32'h0, "R9 0x30 reads zero");
        bus_rd(12'h018, 32'hAAAA_5555, "R9 maxcur0 untouched");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule